// File: doc/BRIEF.md
# Three-Channel Timer Register Bank

This block is the byte-wide, processor-facing register bank of a three-channel down-counting timer. It turns single-cycle bus accesses, made of a valid strobe, a read/write flag, a 3-bit select and a data byte, into writes to three control bytes, a shared high-byte staging register and three 16-bit reload latches. It also serves reads of status, of counter high bytes and of a low-byte holding register. The control bytes and latches drive the counting channels, which sit outside this block.

The block also owns the per-channel interrupt flags. A channel's time-out pulse sets its flag. Each flag can be masked into a composite bit, and that bit drives an active-low interrupt request. Flags are cleared in three ways: by a write to that channel's latch, by a counter-initialization pulse from that channel, or by reading that channel's counter. The counter read clears the flag only if status was read earlier while the flag was set, so that a time-out arriving between the two reads is not lost.

The block has two reset sources. The synchronous external reset restores every register to its power-up value. Bit 0 of control byte 1 acts as an internal reset: while it is set, all flags are held clear, and the latches and control bytes keep their values and remain writable.

Top module: `tmr_regbank`

## Requirements
- R1: A write at select 1 loads control byte 2. A write at select 0 loads control byte 1 when bit 0 of control byte 2 is 1, and loads control byte 3 when that bit is 0. Control byte c appears on ctrl_out[8c-1:8c-8] in the cycle after the write.
- R2: Writes at selects 2, 4 and 6 all load the same high-byte staging register. A write at select 3, 5 or 7 loads latch 1, 2 or 3 respectively with {staging, data}. In the cycle after such a write the new value is on latch_out, and the matching latch_wr bit is high for exactly one cycle.
- R3: A read at select 2, 4 or 6 returns the high byte of counter 1, 2 or 3 (cnt_val) on rd_data in the cycle after the access. rd_data keeps that value until the next read.
- R4: A counter high-byte read also captures that counter's low byte into a holding register. A later read at any of selects 3, 5 or 7 returns the held byte.
- R5: A read at select 0 returns 0x00. In a status read, bits 6 to 3 are always 0.
- R6: A time_out pulse on channel c sets flag c, which reads as status bit c-1 (bits 0, 1, 2 for channels 1, 2, 3).
- R7: Status bit 7 is the OR, over the three channels, of (flag AND bit 6 of that channel's control byte). irq_n is low exactly while status bit 7 is 1.
- R8: Reading channel c's counter clears flag c only if a status read had been made while flag c was set. Without that earlier status read, the flag stays set.
- R9: A latch write for channel c, or a cnt_init pulse on channel c, clears flag c.
- R10: External reset (rst high at a clock edge) sets all latches to 0xFFFF, sets control byte 1 to 0x01, clears control bytes 2 and 3, clears all flags and clears rd_data.
- R11: While bit 0 of control byte 1 is 1, time-out pulses leave all flags clear and irq_n stays high. During this time the latches keep their values and both latches and control bytes still accept writes.
- R12: Control bytes are passed to the channels unchanged, bit for bit. In particular, bit 0 of control byte 3 (the divide-by-8 prescaler select) and bit 1 of each byte (the clock source select) reach ctrl_out as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high external reset |
| acc_valid | input | 1 | One-cycle bus access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 3 | Register select |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| time_out | input | 3 | Per-channel time-out pulses |
| cnt_init | input | 3 | Per-channel counter-initialization pulses |
| cnt_val | input | 48 | Counter values, channel c on bits [16c-1:16c-16] |
| ctrl_out | output | 24 | Control bytes, channel c on bits [8c-1:8c-8] |
| latch_out | output | 48 | Reload latches, channel c on bits [16c-1:16c-16] |
| latch_wr | output | 3 | One-cycle pulse after a latch write |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every result of this block is due one clock edge after its cause. A write changes ctrl_out, latch_out and latch_wr after the edge that samples it. A read changes rd_data after the edge that samples it. A time_out or cnt_init pulse changes the flags, and so irq_n, after the edge that samples it. The bench drives each stimulus on a falling edge, holds it across one rising edge, and checks the outputs on the next falling edge, so each check lands in the first cycle where the result is due.

// File: rtl/tmr_regbank_pkg.sv
package tmr_regbank_pkg;
  localparam int NUM_CH    = 3;   // fixed by the 3-bit select map
  localparam int SEL_W     = 3;
  localparam int HOLD_BIT  = 0;   // internal reset, control byte 1
  localparam int STEER_BIT = 0;   // shared-address steer, control byte 2
  localparam int MASK_BIT  = 6;   // interrupt enable, every control byte

  localparam logic [SEL_W-1:0] SEL_SHARED = 3'd0;
  localparam logic [SEL_W-1:0] SEL_C2     = 3'd1;

  // select of channel c (0-based) high-byte / counter address
  function automatic logic [SEL_W-1:0] sel_hi(input int c);
    return SEL_W'(2 * c + 2);
  endfunction

  // select of channel c (0-based) latch / low-byte address
  function automatic logic [SEL_W-1:0] sel_lo(input int c);
    return SEL_W'(2 * c + 3);
  endfunction
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_regbank_pkg::*;
(
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic [SEL_W-1:0]  acc_sel,
  input  logic              steer,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic              wr_msb,
  output logic [NUM_CH-1:0] wr_latch,
  output logic              rd_status,
  output logic [NUM_CH-1:0] rd_cnt,
  output logic              rd_lsb,
  output logic              rd_any
);
  logic wr_go, rd_go;
  assign wr_go = acc_valid & acc_wr;
  assign rd_go = acc_valid & ~acc_wr;

  assign wr_ctrl[0] = wr_go & (acc_sel == SEL_SHARED) & steer;
  assign wr_ctrl[1] = wr_go & (acc_sel == SEL_C2);
  assign wr_ctrl[2] = wr_go & (acc_sel == SEL_SHARED) & ~steer;

  assign wr_msb    = wr_go & (acc_sel != '0) & ~acc_sel[0];
  assign rd_status = rd_go & (acc_sel == SEL_C2);
  assign rd_lsb    = rd_go & acc_sel[0] & (|acc_sel[SEL_W-1:1]);
  assign rd_any    = rd_go;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    assign wr_latch[c] = wr_go & (acc_sel == sel_lo(c));
    assign rd_cnt[c]   = rd_go & (acc_sel == sel_hi(c));
  end
endmodule

// File: rtl/tmr_ctrl_bank.sv
module tmr_ctrl_bank
  import tmr_regbank_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_CH-1:0]        wr_ctrl,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*DATA_W-1:0] ctrl_q
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_reg
    localparam logic [DATA_W-1:0] RST_VAL =
      (c == 0) ? DATA_W'(1 << HOLD_BIT) : '0;
    always_ff @(posedge clk) begin
      if (rst)             ctrl_q[c*DATA_W +: DATA_W] <= RST_VAL;
      else if (wr_ctrl[c]) ctrl_q[c*DATA_W +: DATA_W] <= wr_data;
    end
  end
endmodule

// File: rtl/tmr_latch_bank.sv
module tmr_latch_bank
  import tmr_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_msb,
  input  logic [NUM_CH-1:0]       wr_latch,
  input  logic [DATA_W-1:0]       wr_data,
  output logic [NUM_CH*CNT_W-1:0] latch_q,
  output logic [NUM_CH-1:0]       latch_wr
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst)         stage_q <= '0;
    else if (wr_msb) stage_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) latch_wr <= '0;
    else     latch_wr <= wr_latch;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)              latch_q[c*CNT_W +: CNT_W] <= '1;
      else if (wr_latch[c]) latch_q[c*CNT_W +: CNT_W] <= {stage_q, wr_data};
    end
  end
endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank
  import tmr_regbank_pkg::*;
(
  input  logic              clk,
  input  logic              hold,
  input  logic [NUM_CH-1:0] time_out,
  input  logic [NUM_CH-1:0] cnt_init,
  input  logic [NUM_CH-1:0] wr_latch,
  input  logic              rd_status,
  input  logic [NUM_CH-1:0] rd_cnt,
  input  logic [NUM_CH-1:0] mask,
  output logic [NUM_CH-1:0] flag_q,
  output logic              composite
);
  logic [NUM_CH-1:0] armed_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flag
    logic clr;
    assign clr = wr_latch[c] | cnt_init[c] | (rd_cnt[c] & armed_q[c]);
    always_ff @(posedge clk) begin
      if (hold) begin
        flag_q[c]  <= 1'b0;
        armed_q[c] <= 1'b0;
      end else if (time_out[c]) begin
        // a new time-out wins over any clear in the same cycle
        flag_q[c]  <= 1'b1;
        if (rd_cnt[c]) armed_q[c] <= 1'b0;
      end else if (clr) begin
        flag_q[c]  <= 1'b0;
        armed_q[c] <= 1'b0;
      end else if (rd_status & flag_q[c]) begin
        armed_q[c] <= 1'b1;
      end
    end
  end

  assign composite = |(flag_q & mask);
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
  import tmr_regbank_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = 2 * DATA_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     acc_valid,
  input  logic                     acc_wr,
  input  logic [SEL_W-1:0]         acc_sel,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        rd_data,
  input  logic [NUM_CH-1:0]        time_out,
  input  logic [NUM_CH-1:0]        cnt_init,
  input  logic [NUM_CH*CNT_W-1:0]  cnt_val,
  output logic [NUM_CH*DATA_W-1:0] ctrl_out,
  output logic [NUM_CH*CNT_W-1:0]  latch_out,
  output logic [NUM_CH-1:0]        latch_wr,
  output logic                     irq_n
);
  logic [NUM_CH-1:0] wr_ctrl, wr_latch, rd_cnt, flags, mask;
  logic              wr_msb, rd_status, rd_lsb, rd_any, composite, hold;
  logic [DATA_W-1:0] lsb_q, rd_next, lsb_next, status_byte;

  tmr_bus_decode u_dec (
    .acc_valid (acc_valid),
    .acc_wr    (acc_wr),
    .acc_sel   (acc_sel),
    .steer     (ctrl_out[DATA_W + STEER_BIT]),
    .wr_ctrl   (wr_ctrl),
    .wr_msb    (wr_msb),
    .wr_latch  (wr_latch),
    .rd_status (rd_status),
    .rd_cnt    (rd_cnt),
    .rd_lsb    (rd_lsb),
    .rd_any    (rd_any)
  );

  tmr_ctrl_bank #(.DATA_W(DATA_W)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_ctrl (wr_ctrl),
    .wr_data (wr_data),
    .ctrl_q  (ctrl_out)
  );

  tmr_latch_bank #(.DATA_W(DATA_W)) u_lat (
    .clk      (clk),
    .rst      (rst),
    .wr_msb   (wr_msb),
    .wr_latch (wr_latch),
    .wr_data  (wr_data),
    .latch_q  (latch_out),
    .latch_wr (latch_wr)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mask
    assign mask[c] = ctrl_out[c*DATA_W + MASK_BIT];
  end

  assign hold = rst | ctrl_out[HOLD_BIT];

  tmr_flag_bank u_flag (
    .clk       (clk),
    .hold      (hold),
    .time_out  (time_out),
    .cnt_init  (cnt_init),
    .wr_latch  (wr_latch),
    .rd_status (rd_status),
    .rd_cnt    (rd_cnt),
    .mask      (mask),
    .flag_q    (flags),
    .composite (composite)
  );

  always_comb begin
    status_byte             = '0;
    status_byte[DATA_W-1]   = composite;
    status_byte[NUM_CH-1:0] = flags;
  end

  always_comb begin
    rd_next  = rd_data;
    lsb_next = lsb_q;
    if (rd_any)    rd_next = '0;
    if (rd_status) rd_next = status_byte;
    if (rd_lsb)    rd_next = lsb_q;
    for (int c = 0; c < NUM_CH; c++) begin
      if (rd_cnt[c]) begin
        rd_next  = cnt_val[c*CNT_W + DATA_W +: DATA_W];
        lsb_next = cnt_val[c*CNT_W +: DATA_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      lsb_q   <= '0;
    end else begin
      rd_data <= rd_next;
      lsb_q   <= lsb_next;
    end
  end

  assign irq_n = ~composite;
endmodule

// File: rtl/tmr_regbank_chk.sv
module tmr_regbank_chk (
  input logic        clk,
  input logic        rst,
  input logic        acc_valid,
  input logic        acc_wr,
  input logic [2:0]  acc_sel,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic [2:0]  time_out,
  input logic [23:0] ctrl_out,
  input logic [47:0] latch_out,
  input logic [2:0]  latch_wr,
  input logic        irq_n
);
  // R1
  ctrl2_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_wr && acc_sel == 3'd1) |=> ctrl_out[15:8] == $past(wr_data));

  // R2
  latch1_write_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_wr && acc_sel == 3'd3) |=>
      (latch_out[7:0] == $past(wr_data) && latch_wr[0]));

  // R5
  nop_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr && acc_sel == 3'd0) |=> rd_data == 8'h00);

  // R5
  status_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && !acc_wr && acc_sel == 3'd1) |=> rd_data[6:3] == 4'h0);

  // R7
  masked_timeout_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (time_out[0] && ctrl_out[6] && !ctrl_out[0] && !(acc_valid && acc_wr))
      |=> !irq_n);

  // R11
  hold_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_out[0]) |-> irq_n);

  // R10
  reset_value_chk: assert property (@(posedge clk)
    rst |=> (latch_out == {48{1'b1}} && ctrl_out == 24'h000001));
endmodule

bind tmr_regbank tmr_regbank_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .acc_valid (acc_valid),
  .acc_wr    (acc_wr),
  .acc_sel   (acc_sel),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .time_out  (time_out),
  .ctrl_out  (ctrl_out),
  .latch_out (latch_out),
  .latch_wr  (latch_wr),
  .irq_n     (irq_n)
);

// File: tb/tmr_regbank_tb.sv
`timescale 1ns/100ps
module tmr_regbank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_wr = 1'b0;
  logic [2:0]  acc_sel = '0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic [2:0]  time_out = '0, cnt_init = '0;
  logic [47:0] cnt_val = {16'hE5F6, 16'hC3D4, 16'hA1B2};
  logic [23:0] ctrl_out;
  logic [47:0] latch_out;
  logic [2:0]  latch_wr;
  logic        irq_n;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tmr_regbank u_dut (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_wr(acc_wr),
    .acc_sel(acc_sel), .wr_data(wr_data), .rd_data(rd_data),
    .time_out(time_out), .cnt_init(cnt_init), .cnt_val(cnt_val),
    .ctrl_out(ctrl_out), .latch_out(latch_out), .latch_wr(latch_wr),
    .irq_n(irq_n)
  );

  // entry: {req[3:0], wr, sel[2:0], data[7:0], expected read[7:0]}
  localparam int NV = 20;
  localparam logic [23:0] VEC [0:NV-1] = '{
    {4'd5,  1'b0, 3'd1, 8'h00, 8'h00},  // R5 status after reset
    {4'd1,  1'b1, 3'd1, 8'h01, 8'h00},  // R1 steer to control byte 1
    {4'd1,  1'b1, 3'd0, 8'h40, 8'h00},  // R1 control byte 1, hold off
    {4'd1,  1'b1, 3'd1, 8'h40, 8'h00},  // R1 steer to control byte 3
    {4'd1,  1'b1, 3'd0, 8'h41, 8'h00},  // R1 control byte 3
    {4'd2,  1'b1, 3'd2, 8'h12, 8'h00},  // R2 staging
    {4'd2,  1'b1, 3'd3, 8'h34, 8'h00},  // R2 latch 1
    {4'd2,  1'b1, 3'd6, 8'hAB, 8'h00},  // R2 staging via other select
    {4'd2,  1'b1, 3'd5, 8'hCD, 8'h00},  // R2 latch 2
    {4'd2,  1'b1, 3'd4, 8'h56, 8'h00},  // R2 staging
    {4'd2,  1'b1, 3'd7, 8'h78, 8'h00},  // R2 latch 3
    {4'd5,  1'b0, 3'd0, 8'h00, 8'h00},  // R5 no-op read
    {4'd3,  1'b0, 3'd2, 8'h00, 8'hA1},  // R3 counter 1 high
    {4'd4,  1'b0, 3'd3, 8'h00, 8'hB2},  // R4 held low byte
    {4'd3,  1'b0, 3'd4, 8'h00, 8'hC3},  // R3 counter 2 high
    {4'd4,  1'b0, 3'd7, 8'h00, 8'hD4},  // R4 any low select
    {4'd3,  1'b0, 3'd6, 8'h00, 8'hE5},  // R3 counter 3 high
    {4'd4,  1'b0, 3'd5, 8'h00, 8'hF6},  // R4
    {4'd4,  1'b0, 3'd3, 8'h00, 8'hF6},  // R4 held value repeats
    {4'd5,  1'b0, 3'd1, 8'h00, 8'h00}   // R5 status clean
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1'b1; acc_wr = wr; acc_sel = sel; wr_data = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic pulse(input logic [2:0] to, input logic [2:0] ci);
    @(negedge clk);
    time_out = to; cnt_init = ci;
    @(negedge clk);
    time_out = '0; cnt_init = '0;
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 latches", latch_out, {48{1'b1}});
    chk("R10 ctrl", ctrl_out, 24'h000001);
    chk("R10 irq_n", irq_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      if (!VEC[i][19]) begin
        checks++;
        if (rd_data !== VEC[i][7:0]) begin
          errors++;
          $display("FAIL R%0d table[%0d]: actual %0h expected %0h",
                   VEC[i][23:20], i, rd_data, VEC[i][7:0]);
        end
      end
    end
    chk("R1 ctrl bytes", ctrl_out, 24'h414040);
    chk("R2 latches", latch_out, {16'h5678, 16'hABCD, 16'h1234});
    chk("R12 prescale bit", ctrl_out[16], 1'b1);

    // R2 latch_wr pulse length
    @(negedge clk);
    acc_valid = 1; acc_wr = 1; acc_sel = 3'd5; wr_data = 8'hCD;
    @(negedge clk);
    acc_valid = 0; acc_wr = 0;
    chk("R2 latch_wr high", latch_wr, 3'b010);
    @(negedge clk);
    chk("R2 latch_wr one cycle", latch_wr, 3'b000);

    // R6 R7 R8: armed clear
    pulse(3'b001, 3'b000);
    chk("R7 irq low", irq_n, 1'b0);
    access(1'b0, 3'd1, 8'h00);
    chk("R6 status", rd_data, 8'h81);
    access(1'b0, 3'd2, 8'h00);
    chk("R8 cnt read", rd_data, 8'hA1);
    chk("R8 irq released", irq_n, 1'b1);
    access(1'b0, 3'd1, 8'h00);
    chk("R8 flag cleared", rd_data, 8'h00);

    // R8 unarmed read keeps flag
    pulse(3'b010, 3'b000);
    chk("R7 irq ch2", irq_n, 1'b0);
    access(1'b0, 3'd4, 8'h00);
    access(1'b0, 3'd1, 8'h00);
    chk("R8 flag kept", rd_data, 8'h82);
    access(1'b0, 3'd4, 8'h00);
    access(1'b0, 3'd1, 8'h00);
    chk("R8 flag cleared ch2", rd_data, 8'h00);

    // R7 unmasked, R9 latch write clear
    access(1'b1, 3'd0, 8'h01);
    chk("R12 ctrl3", ctrl_out[23:16], 8'h01);
    pulse(3'b100, 3'b000);
    chk("R7 unmasked irq", irq_n, 1'b1);
    access(1'b0, 3'd1, 8'h00);
    chk("R6 status ch3", rd_data, 8'h04);
    access(1'b1, 3'd7, 8'h99);
    chk("R2 latch3 old staging", latch_out[47:32], 16'h5699);
    access(1'b0, 3'd1, 8'h00);
    chk("R9 latch write clear", rd_data, 8'h00);

    // R9 cnt_init clear
    pulse(3'b001, 3'b000);
    pulse(3'b000, 3'b001);
    chk("R9 init irq", irq_n, 1'b1);
    access(1'b0, 3'd1, 8'h00);
    chk("R9 init clear", rd_data, 8'h00);

    // R11 internal reset
    access(1'b1, 3'd1, 8'h43);
    chk("R12 clock source bit", ctrl_out[9], 1'b1);
    access(1'b1, 3'd0, 8'h41);
    pulse(3'b001, 3'b000);
    chk("R11 irq held", irq_n, 1'b1);
    access(1'b0, 3'd1, 8'h00);
    chk("R11 flags held", rd_data, 8'h00);
    chk("R11 latch kept", latch_out[15:0], 16'h1234);
    access(1'b1, 3'd2, 8'h0F);
    access(1'b1, 3'd3, 8'hF0);
    chk("R11 latch writable", latch_out[15:0], 16'h0FF0);
    chk("R11 ctrl kept", ctrl_out[7:0], 8'h41);
    access(1'b1, 3'd0, 8'h40);
    pulse(3'b001, 3'b000);
    access(1'b0, 3'd1, 8'h00);
    chk("R11 release", rd_data, 8'h81);

    // R10 external reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R10 latches again", latch_out, {48{1'b1}});
    chk("R10 ctrl again", ctrl_out, 24'h000001);
    chk("R10 irq", irq_n, 1'b1);
    chk("R10 rd_data", rd_data, 8'h00);
    access(1'b0, 3'd1, 8'h00);
    chk("R10 flags", rd_data, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule